// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block runs whole I2C transactions on behalf of a host: a write, an offset-then-read, or a presence probe. It does not drive the bus wires. It drives a byte-level master core through a narrow control/status interface. Each step is one control write, optionally with a byte to send. After that write the sequencer polls the core until the core raises its step-complete flag. It then checks the status code the core reports against the code that step should produce.

A command carries a 7-bit target address, an offset of 0 to 4 bytes, and a byte count. Write data is pulled from the host over a valid/ready pair, and read data is pushed back with a one-cycle valid strobe. Every transaction ends with a STOP, including a transaction that failed. The outcome is a 32-bit code presented with a one-cycle done pulse. The code is zero on success. On failure it records the error class, the control byte of the step that failed, the status seen and the status expected.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A write command issues these steps in order: START (control 0x60, expect 0x08), address byte {addr,0} (control 0x40, expect 0x18), the offset bytes, the data bytes (control 0x40, each expect 0x28), then STOP (control 0x50). The control bits are: enable bit 6, start bit 5, stop bit 4, flag bit 3, ack bit 2.
- R2: Offset bytes are taken from cmd_off_i and sent starting at byte index len-1 and ending at index 0. Byte i is cmd_off_i[8i+7:8i], and the offset length is 0 to 4.
- R3: A read with a nonzero offset first sends START, {addr,0} and the offset bytes. It then issues a repeated START (control 0x60, expect 0x10) with no STOP in between. A read with no offset starts with a plain START that expects 0x08.
- R4: A read addresses the target with {addr,1} and expects 0x40. Every byte except the last is received with control 0x44 and expects 0x50. The last byte is received with control 0x40 and expects 0x58. Each good byte appears on rd_data_o with a one-cycle rd_valid_o.
- R5: A probe (op 2 or 3) sends START, {addr,1}, one receive with NAK (control 0x40, expect 0x58), then STOP. The result is 0 when the target answers, and no rd_valid_o is produced.
- R6: The result is {class[31:24], control[23:16], status[15:8], expected[7:0]}. On a status mismatch the class is 0x01 and the control field is the issued control with the flag bit set.
- R7: Each wait polls once every TICK_CYCLES cycles, at most POLL_LIMIT times. Without the flag it fails with class 0x02, the issued control byte and the status seen. The STOP write follows the timed-out step's write by TICK_CYCLES*POLL_LIMIT+1 cycles.
- R8: STOP is complete when the core status reads 0xF8, not when the flag rises. If that never happens, the result is {0x02, 0x50, 0x00, 0xF8}.
- R9: After the first failure only a STOP is issued. The first failure's code wins over a later STOP timeout.
- R10: A command is taken only while cmd_ready_o is high, and commands offered while busy have no effect. done_o is a one-cycle pulse, and result_o holds the code from then on.
- R11: Each data byte of a write waits until wr_valid_i is high. That byte is consumed in the cycle where wr_valid_i and wr_ready_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer idle, command taken |
| cmd_op_i | input | 2 | 0 write, 1 read, 2 or 3 probe |
| cmd_addr_i | input | 7 | Target address |
| cmd_off_i | input | 8*OFF_BYTES | Offset bytes |
| cmd_off_len_i | input | OW | Offset length in bytes |
| cmd_len_i | input | LEN_W | Data byte count |
| wr_valid_i | input | 1 | Write byte available |
| wr_data_i | input | 8 | Write byte |
| wr_ready_o | output | 1 | Write byte consumed when valid |
| rd_valid_o | output | 1 | Read byte strobe |
| rd_data_o | output | 8 | Read byte |
| done_o | output | 1 | Transaction finished |
| result_o | output | 32 | Result code |
| core_ctl_we_o | output | 1 | Control write to core |
| core_ctl_o | output | 8 | Control byte |
| core_tx_o | output | 8 | Byte to send |
| core_flag_i | input | 1 | Core step-complete flag |
| core_status_i | input | 8 | Core status code |
| core_rx_i | input | 8 | Core received byte |

## Verification
The bench builds the block with TICK_CYCLES=2, POLL_LIMIT=8 and LEN_W=4. With these values a timed-out wait lasts only 17 cycles, so every step position can be made to time out cheaply. The bench sweeps all offset lengths 0 to 4 against data counts 0 to 3 for both writes and reads. It also drives a core model that can refuse the address, NAK a chosen byte, stall a chosen step or never return to idle after STOP. This covers every failure position, the priority of the first failure over a STOP timeout, and the exact length of the timeout window.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam logic [7:0] CTL_ACK   = 8'h04;
  localparam logic [7:0] CTL_FLAG  = 8'h08;
  localparam logic [7:0] CTL_STOP  = 8'h10;
  localparam logic [7:0] CTL_START = 8'h20;
  localparam logic [7:0] CTL_EN    = 8'h40;

  localparam logic [7:0] ST_START  = 8'h08;
  localparam logic [7:0] ST_RSTART = 8'h10;
  localparam logic [7:0] ST_AW_ACK = 8'h18;
  localparam logic [7:0] ST_DW_ACK = 8'h28;
  localparam logic [7:0] ST_AR_ACK = 8'h40;
  localparam logic [7:0] ST_DR_ACK = 8'h50;
  localparam logic [7:0] ST_DR_NAK = 8'h58;
  localparam logic [7:0] ST_IDLE   = 8'hF8;

  localparam logic [7:0] ERR_STATUS  = 8'h01;
  localparam logic [7:0] ERR_TIMEOUT = 8'h02;

  typedef enum logic [2:0] {
    PH_START, PH_WADDR, PH_OFF, PH_DATA, PH_RSTART, PH_RADDR, PH_RECV, PH_STOP
  } phase_e;
endpackage

// File: rtl/i2cs_poll.sv
module i2cs_poll import i2cs_pkg::*; #(
  parameter int TICK_CYCLES = 500,
  parameter int POLL_LIMIT  = 1000,
  localparam int TW = $clog2(TICK_CYCLES + 1),
  localparam int PW = $clog2(POLL_LIMIT + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kick_i,
  input  logic       stop_mode_i,
  input  logic       flag_i,
  input  logic [7:0] status_i,
  output logic       hit_o,
  output logic       expire_o
);
  logic          active_q;
  logic [TW-1:0] tick_q;
  logic [PW-1:0] polls_q;
  logic          poll_now, cond, last;

  assign poll_now = active_q && (tick_q == TW'(TICK_CYCLES - 1));
  assign cond     = stop_mode_i ? (status_i == ST_IDLE) : flag_i;
  assign last     = (polls_q == PW'(POLL_LIMIT - 1));
  assign hit_o    = poll_now && cond;
  assign expire_o = poll_now && !cond && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tick_q   <= '0;
      polls_q  <= '0;
    end else if (kick_i) begin
      active_q <= 1'b1;
      tick_q   <= '0;
      polls_q  <= '0;
    end else if (active_q) begin
      if (poll_now) begin
        tick_q <= '0;
        if (cond || last) active_q <= 1'b0;
        else              polls_q  <= polls_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_off_pick.sv
module i2cs_off_pick #(
  parameter int OFF_BYTES = 4,
  parameter int IDX_W     = 3
) (
  input  logic [OFF_BYTES*8-1:0] off_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [7:0]             byte_o
);
  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < OFF_BYTES; i++)
      if (idx_i == IDX_W'(i)) byte_o = off_i[i*8 +: 8];
  end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq import i2cs_pkg::*; #(
  parameter int OFF_BYTES   = 4,
  parameter int LEN_W       = 8,
  parameter int TICK_CYCLES = 500,
  parameter int POLL_LIMIT  = 1000,
  localparam int OW = $clog2(OFF_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_valid_i,
  output logic                   cmd_ready_o,
  input  logic [1:0]             cmd_op_i,
  input  logic [6:0]             cmd_addr_i,
  input  logic [OFF_BYTES*8-1:0] cmd_off_i,
  input  logic [OW-1:0]          cmd_off_len_i,
  input  logic [LEN_W-1:0]       cmd_len_i,
  input  logic                   wr_valid_i,
  input  logic [7:0]             wr_data_i,
  output logic                   wr_ready_o,
  output logic                   rd_valid_o,
  output logic [7:0]             rd_data_o,
  output logic                   done_o,
  output logic [31:0]            result_o,
  output logic                   core_ctl_we_o,
  output logic [7:0]             core_ctl_o,
  output logic [7:0]             core_tx_o,
  input  logic                   core_flag_i,
  input  logic [7:0]             core_status_i,
  input  logic [7:0]             core_rx_i
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;

  st_e                   st_q;
  phase_e                ph_q, nxt_ph;
  logic                  rd_q, probe_q;
  logic [6:0]            addr_q;
  logic [OFF_BYTES*8-1:0] off_q;
  logic [OW-1:0]         off_left_q;
  logic [LEN_W-1:0]      len_left_q;
  logic [7:0]            ctl_q, exp_q, ctl_n, tx_n, exp_n, off_byte;
  logic [31:0]           err_q, res_q;
  logic                  done_q, rdv_q;
  logic [7:0]            rdd_q;
  logic                  go, hit, expire, more_len;

  i2cs_off_pick #(.OFF_BYTES(OFF_BYTES), .IDX_W(OW)) u_pick (
    .off_i(off_q), .idx_i(off_left_q - 1'b1), .byte_o(off_byte)
  );

  i2cs_poll #(.TICK_CYCLES(TICK_CYCLES), .POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk_i(clk_i), .rst_ni(rst_ni), .kick_i(go), .stop_mode_i(ph_q == PH_STOP),
    .flag_i(core_flag_i), .status_i(core_status_i), .hit_o(hit), .expire_o(expire)
  );

  assign more_len = (len_left_q > LEN_W'(1));

  always_comb begin
    ctl_n = CTL_EN;
    tx_n  = 8'h00;
    exp_n = ST_IDLE;
    unique case (ph_q)
      PH_START:  begin ctl_n = CTL_EN | CTL_START; exp_n = ST_START;  end
      PH_RSTART: begin ctl_n = CTL_EN | CTL_START; exp_n = ST_RSTART; end
      PH_WADDR:  begin tx_n = {addr_q, 1'b0}; exp_n = ST_AW_ACK; end
      PH_RADDR:  begin tx_n = {addr_q, 1'b1}; exp_n = ST_AR_ACK; end
      PH_OFF:    begin tx_n = off_byte;       exp_n = ST_DW_ACK; end
      PH_DATA:   begin tx_n = wr_data_i;      exp_n = ST_DW_ACK; end
      PH_RECV:   begin
        ctl_n = more_len ? (CTL_EN | CTL_ACK) : CTL_EN;
        exp_n = more_len ? ST_DR_ACK : ST_DR_NAK;
      end
      default:   ctl_n = CTL_EN | CTL_STOP;
    endcase
  end

  always_comb begin
    unique case (ph_q)
      PH_START:  nxt_ph = (rd_q && off_left_q == '0) ? PH_RADDR : PH_WADDR;
      PH_RSTART: nxt_ph = PH_RADDR;
      PH_WADDR:  nxt_ph = (off_left_q != '0) ? PH_OFF :
                          (len_left_q != '0) ? PH_DATA : PH_STOP;
      PH_OFF:    nxt_ph = (off_left_q > OW'(1)) ? PH_OFF : rd_q ? PH_RSTART :
                          (len_left_q != '0) ? PH_DATA : PH_STOP;
      PH_DATA:   nxt_ph = more_len ? PH_DATA : PH_STOP;
      PH_RADDR:  nxt_ph = (len_left_q != '0) ? PH_RECV : PH_STOP;
      PH_RECV:   nxt_ph = more_len ? PH_RECV : PH_STOP;
      default:   nxt_ph = PH_STOP;
    endcase
  end

  assign go            = (st_q == S_ISSUE) && (ph_q != PH_DATA || wr_valid_i);
  assign wr_ready_o    = (st_q == S_ISSUE) && (ph_q == PH_DATA);
  assign cmd_ready_o   = (st_q == S_IDLE);
  assign core_ctl_we_o = go;
  assign core_ctl_o    = ctl_n;
  assign core_tx_o     = tx_n;
  assign done_o        = done_q;
  assign result_o      = res_q;
  assign rd_valid_o    = rdv_q;
  assign rd_data_o     = rdd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;  ph_q <= PH_STOP;
      rd_q <= 1'b0;    probe_q <= 1'b0;  addr_q <= '0;  off_q <= '0;
      off_left_q <= '0; len_left_q <= '0;
      ctl_q <= '0; exp_q <= '0; err_q <= '0; res_q <= '0;
      done_q <= 1'b0; rdv_q <= 1'b0; rdd_q <= '0;
    end else begin
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: if (cmd_valid_i) begin
          rd_q       <= (cmd_op_i != 2'b00);
          probe_q    <= cmd_op_i[1];
          addr_q     <= cmd_addr_i;
          off_q      <= cmd_off_i;
          off_left_q <= cmd_op_i[1] ? '0 : cmd_off_len_i;
          len_left_q <= cmd_op_i[1] ? LEN_W'(1) : cmd_len_i;
          err_q      <= '0;
          ph_q       <= PH_START;
          st_q       <= S_ISSUE;
        end
        S_ISSUE: if (go) begin
          ctl_q <= ctl_n;
          exp_q <= exp_n;
          st_q  <= S_WAIT;
        end
        S_WAIT: begin
          if (ph_q == PH_STOP) begin
            if (hit || expire) begin
              done_q <= 1'b1;
              res_q  <= (expire && err_q == '0) ?
                        {ERR_TIMEOUT, ctl_q, 8'h00, ST_IDLE} : err_q;
              st_q   <= S_IDLE;
            end
          end else if (hit) begin
            st_q <= S_ISSUE;
            if (core_status_i == exp_q) begin
              ph_q <= nxt_ph;
              if (ph_q == PH_OFF) off_left_q <= off_left_q - 1'b1;
              if (ph_q == PH_DATA || ph_q == PH_RECV) len_left_q <= len_left_q - 1'b1;
              if (ph_q == PH_RECV && !probe_q) begin
                rdv_q <= 1'b1;
                rdd_q <= core_rx_i;
              end
            end else begin
              err_q <= {ERR_STATUS, ctl_q | CTL_FLAG, core_status_i, exp_q};
              ph_q  <= PH_STOP;
            end
          end else if (expire) begin
            err_q <= {ERR_TIMEOUT, ctl_q, core_status_i, exp_q};
            ph_q  <= PH_STOP;
            st_q  <= S_ISSUE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic        cmd_ready_o,
  input logic        wr_ready_o,
  input logic        rd_valid_o,
  input logic        done_o,
  input logic [31:0] result_o,
  input logic        core_ctl_we_o,
  input logic [7:0]  core_ctl_o
);
  logic stop_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          stop_seen <= 1'b0;
    else if (cmd_valid_i && cmd_ready_o)  stop_seen <= 1'b0;
    else if (core_ctl_we_o && core_ctl_o[4]) stop_seen <= 1'b1;
  end

  a_r1_one_write_per_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ctl_we_o |=> !core_ctl_we_o);
  a_r1_no_start_with_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ctl_we_o |-> !(core_ctl_o[5] && core_ctl_o[4]));
  a_r9_nothing_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_seen |-> !core_ctl_we_o);
  a_r9_done_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> stop_seen);
  a_r10_accept_leaves_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_wr_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> !cmd_ready_o);
  a_r4_rd_valid_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !cmd_ready_o);
  a_r6_mismatch_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o[31:24] == 8'h01) |-> result_o[19]);
  a_r8_stop_timeout_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o[31:24] == 8'h02 && result_o[7:0] == 8'hF8) |-> (result_o[15:8] == 8'h00));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .wr_ready_o(wr_ready_o), .rd_valid_o(rd_valid_o), .done_o(done_o), .result_o(result_o),
  .core_ctl_we_o(core_ctl_we_o), .core_ctl_o(core_ctl_o)
);

// File: tb/i2c_xfer_seq_bench.sv
module i2c_xfer_seq_bench;
  localparam int TICK = 2, PLIM = 8, OFFB = 4, LW = 4, LAT = 3, OW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n = 1'b0;

  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [6:0] cmd_addr = 7'h2A;
  logic [31:0] cmd_off = 32'h0;
  logic [OW-1:0] cmd_off_len = '0;
  logic [LW-1:0] cmd_len = '0;
  logic wr_valid, wr_ready, rd_valid, done, ctl_we, flag;
  logic [7:0] wr_data, rd_data, ctl, tx, status, rx;
  logic [31:0] result;

  i2c_xfer_seq #(.OFF_BYTES(OFFB), .LEN_W(LW), .TICK_CYCLES(TICK), .POLL_LIMIT(PLIM)) u_i2c_xfer_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr), .cmd_off_i(cmd_off), .cmd_off_len_i(cmd_off_len),
    .cmd_len_i(cmd_len), .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .done_o(done), .result_o(result),
    .core_ctl_we_o(ctl_we), .core_ctl_o(ctl), .core_tx_o(tx), .core_flag_i(flag),
    .core_status_i(status), .core_rx_i(rx)
  );

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // host write stream with stalls
  logic stall = 1'b0;
  int wr_idx = 0;
  always @(negedge clk) stall <= ~stall;
  assign wr_valid = stall;
  assign wr_data  = 8'hC0 + 8'(wr_idx);
  always @(posedge clk) if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;

  // result and read capture
  int rd_n = 0, done_n = 0;
  logic [7:0] rd_buf [0:2047];
  logic [31:0] last_res = '0;
  always @(posedge clk) begin
    if (rd_valid) begin rd_buf[rd_n] <= rd_data; rd_n <= rd_n + 1; end
    if (done) begin done_n <= done_n + 1; last_res <= result; end
  end

  function automatic logic [7:0] rx_pat(int k);
    return 8'h5A ^ 8'(k * 17);
  endfunction

  // core model
  logic [6:0] cfg_present = 7'h2A;
  int cfg_nak_at = -1, cfg_stuck = -1;
  logic cfg_stop_stuck = 1'b0;
  logic m_flag, m_nflag, m_after, m_in, m_rd;
  logic [7:0] m_status, m_next, m_rx;
  int m_cnt, m_idx, nlog = 0;
  logic [7:0] log_ctl [0:2047];
  logic [7:0] log_tx  [0:2047];
  int log_t [0:2047];
  assign flag = m_flag;
  assign status = m_status;
  assign rx = m_rx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag <= 1'b0; m_nflag <= 1'b0; m_status <= 8'hF8; m_next <= 8'hF8; m_cnt <= 0;
      m_after <= 1'b0; m_in <= 1'b0; m_rd <= 1'b0; m_idx <= 0; m_rx <= 8'h00;
    end else if (ctl_we) begin
      log_ctl[nlog] <= ctl; log_tx[nlog] <= tx; log_t[nlog] <= cyc;
      nlog <= nlog + 1;
      m_flag <= 1'b0;
      if (ctl[4]) begin
        m_in <= 1'b0; m_next <= 8'hF8; m_nflag <= 1'b0;
        m_cnt <= cfg_stop_stuck ? 0 : LAT;
      end else begin
        m_status <= 8'hF8; m_nflag <= 1'b1;
        m_cnt <= (nlog == cfg_stuck) ? 0 : LAT;
        if (ctl[5]) begin
          m_next <= m_in ? 8'h10 : 8'h08; m_in <= 1'b1; m_after <= 1'b1;
        end else if (m_after) begin
          m_after <= 1'b0; m_rd <= tx[0]; m_idx <= 0;
          m_next <= tx[0] ? ((tx[7:1] == cfg_present) ? 8'h40 : 8'h48)
                          : ((tx[7:1] == cfg_present) ? 8'h18 : 8'h20);
        end else if (m_rd) begin
          m_next <= ctl[2] ? 8'h50 : 8'h58; m_rx <= rx_pat(m_idx); m_idx <= m_idx + 1;
        end else begin
          m_next <= (m_idx == cfg_nak_at) ? 8'h30 : 8'h28; m_idx <= m_idx + 1;
        end
      end
    end else if (m_cnt > 0) begin
      m_cnt <= m_cnt - 1;
      if (m_cnt == 1) begin m_status <= m_next; m_flag <= m_nflag; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  logic [7:0] e_ctl [0:31];
  logic [7:0] e_tx  [0:31];
  bit e_has [0:31];
  int ne;

  task automatic push(input logic [7:0] c, input logic [7:0] t, input bit h);
    e_ctl[ne] = c; e_tx[ne] = t; e_has[ne] = h; ne++;
  endtask

  // op: 0 write, 1 read, 2 probe; keep<0 means full sequence; stuck: step index or -1
  task automatic run(input int op, input int n, input int len, input int keep,
                     input logic [31:0] exp_res, input int stuck, input bit poke, input string req);
    int base_log, base_rd, base_done, base_wr, g;
    logic [31:0] off;
    off = 32'hA1B2C3D4;
    base_log = nlog; base_rd = rd_n; base_done = done_n; base_wr = wr_idx;
    ne = 0;
    push(8'h60, 8'h00, 1'b0);
    if (op == 0 || (op == 1 && n > 0)) begin
      push(8'h40, {7'h2A, 1'b0}, 1'b1);
      for (int i = n - 1; i >= 0; i--) push(8'h40, off[i*8 +: 8], 1'b1);
    end
    if (op == 0) begin
      for (int k = 0; k < len; k++) push(8'h40, 8'hC0 + 8'(base_wr + k), 1'b1);
    end else begin
      if (op == 1 && n > 0) push(8'h60, 8'h00, 1'b0);
      push(8'h40, {7'h2A, 1'b1}, 1'b1);
      if (op == 2) push(8'h40, 8'h00, 1'b0);
      else for (int k = 0; k < len; k++) push((k < len - 1) ? 8'h44 : 8'h40, 8'h00, 1'b0);
    end
    if (keep >= 0) ne = keep;
    push(8'h50, 8'h00, 1'b0);
    cfg_stuck = (stuck >= 0) ? base_log + stuck : -1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = 7'h2A; cmd_off = off;
    cmd_off_len = OW'(n); cmd_len = LW'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd2; cmd_off_len = '0; cmd_len = '0;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    g = 0;
    while (done_n == base_done && g < 3000) begin @(negedge clk); g++; end
    repeat (poke ? 30 : 3) @(negedge clk);
    chk(done_n - base_done == 1, {req, " R10 done count"}, done_n - base_done, 1);
    chk(nlog - base_log == ne, {req, " step count"}, nlog - base_log, ne);
    for (int i = 0; i < ne && i < nlog - base_log; i++) begin
      chk(log_ctl[base_log + i] == e_ctl[i], {req, " ctl"}, log_ctl[base_log + i], e_ctl[i]);
      if (e_has[i]) chk(log_tx[base_log + i] == e_tx[i], {req, " byte"}, log_tx[base_log + i], e_tx[i]);
    end
    chk(last_res == exp_res, {req, " result"}, last_res, exp_res);
    if (op == 1 && exp_res == 0) begin
      chk(rd_n - base_rd == len, {req, " R4 read count"}, rd_n - base_rd, len);
      for (int k = 0; k < len && k < rd_n - base_rd; k++)
        chk(rd_buf[base_rd + k] == rx_pat(k), {req, " R4 read byte"}, rd_buf[base_rd + k], rx_pat(k));
    end else begin
      chk(rd_n == base_rd, {req, " R5 no read strobe"}, rd_n - base_rd, 0);
    end
    if (op == 0 && exp_res == 0)
      chk(wr_idx - base_wr == len, {req, " R11 bytes consumed"}, wr_idx - base_wr, len);
    if (stuck >= 0)
      chk(log_t[base_log + stuck + 1] - log_t[base_log + stuck] == TICK * PLIM + 1,
          {req, " R7 window"}, log_t[base_log + stuck + 1] - log_t[base_log + stuck], TICK * PLIM + 1);
    cfg_present = 7'h2A; cfg_nak_at = -1; cfg_stuck = -1; cfg_stop_stuck = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R10 reset ready", cmd_ready, 1);
    chk(done == 1'b0, "R10 reset done", done, 0);
    chk(result == 32'h0, "R6 reset result", result, 0);
    chk(ctl_we == 1'b0 && wr_ready == 1'b0, "R1 reset quiet", {ctl_we, wr_ready}, 0);

    for (int n = 0; n <= 4; n++)
      for (int len = 0; len <= 3; len++)
        run(0, n, len, -1, 32'h0, -1, 1'b0, "R1 R2 R11 write");
    for (int n = 0; n <= 4; n++)
      for (int len = 0; len <= 3; len++)
        run(1, n, len, -1, 32'h0, -1, 1'b0, "R3 R4 read");
    run(2, 0, 0, -1, 32'h0, -1, 1'b0, "R5 probe present");
    cfg_present = 7'h50;
    run(2, 0, 0, 2, 32'h01484840, -1, 1'b0, "R5 R6 probe absent");
    cfg_present = 7'h50;
    run(0, 2, 2, 2, 32'h01482018, -1, 1'b0, "R6 R9 write absent");
    cfg_nak_at = 2;
    run(0, 1, 3, 5, 32'h01483028, -1, 1'b0, "R6 R9 data nak");
    cfg_nak_at = 0;
    run(1, 2, 2, 3, 32'h01483028, -1, 1'b0, "R6 R9 offset nak");
    run(0, 1, 1, 1, 32'h0260F808, 0, 1'b0, "R7 R9 start stuck");
    run(1, 1, 3, 5, 32'h0240F840, 4, 1'b0, "R7 R9 raddr stuck");
    cfg_stop_stuck = 1'b1;
    run(0, 1, 2, -1, 32'h025000F8, -1, 1'b0, "R8 stop stuck");
    cfg_stop_stuck = 1'b1; cfg_present = 7'h50;
    run(0, 1, 2, 2, 32'h01482018, -1, 1'b0, "R8 R9 first failure wins");
    run(0, 2, 3, -1, 32'h0, -1, 1'b1, "R10 busy command ignored");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule